// File: doc/BRIEF.md
# Dual-Width Zero Run Counter

This unit measures how many zero bits stand at one end of a 64-bit operand before the first set bit. A direction input chooses the end. Low means the count starts at the most significant bit of the examined field. High means it starts at the least significant bit. A span input chooses the field. Low means all 64 bits are examined. High means only bits 31 to 0 are examined.

The same datapath covers all four combinations of direction and span. It reverses the operand when counting from the low end, and it left-aligns the low word when the span is narrow. It then finds the first set nibble with a parallel priority pick over sixteen nibble encoders. When no bit is set, the result is the width of the field.

The count is registered once. It appears on a 64-bit result whose bits above bit 6 are always zero.

Top module: `zcount_unit`

## Requirements
- R1: With `trail_i`=0 and `narrow_i`=0, an operand whose highest set bit is at position 63−i yields i, for every i from 0 to 63, whatever the lower bits hold.
- R2: With `trail_i`=1 and `narrow_i`=0, an operand whose lowest set bit is at position i yields i, for every i from 0 to 63, whatever the higher bits hold.
- R3: With `narrow_i`=0, an all-zero operand yields 64 (0x40) in both directions.
- R4: With `narrow_i`=1, operand bits 63 to 32 have no effect on the result.
- R5: With `narrow_i`=1, a zero low word yields 32 (0x20) in both directions, even when upper bits are set.
- R6: With `trail_i`=0 and `narrow_i`=1, a low word whose highest set bit is at position 31−i yields i, for i from 0 to 31.
- R7: With `trail_i`=1 and `narrow_i`=1, a low word whose lowest set bit is at position i yields i, for i from 0 to 31.
- R8: Result bits 63 to 7 are always zero, and the count occupies bits 6 to 0.
- R9: The result reflects the inputs sampled at the previous rising clock edge, so latency is exactly one cycle. A high `rst_i` at a rising edge clears the result to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| operand_i | input | 64 | Value whose zero run is counted |
| trail_i | input | 1 | 0: count from the most significant end; 1: count from the least significant end |
| narrow_i | input | 1 | 0: examine all 64 bits; 1: examine bits 31..0 only |
| result_o | output | 64 | Registered zero count, zero-extended |

## Verification
The bench walks a single leading or trailing set bit through every position of both spans. The bits on the far side of that set bit are random, so a priority pick that chose the wrong nibble, or took the wrong bit inside a nibble, gives an off-by-some count at those positions.

For the narrow span, the bench puts random and all-ones patterns in the upper word. A design that lets the upper word leak in shows smaller counts or misses the saturation at 32. All-zero fields in every mode catch a design that returns 0 or 63 instead of the field width. A mid-run reset and one-cycle-apart patterns catch an extra or missing register stage.

// File: rtl/zcount_pkg.sv
package zcount_pkg;
    localparam int unsigned NIB_W = 4;

    typedef enum logic {
        DIR_LEAD  = 1'b0,
        DIR_TRAIL = 1'b1
    } dir_e;

    typedef enum logic {
        SPAN_FULL = 1'b0,
        SPAN_LOW  = 1'b1
    } span_e;
endpackage

// File: rtl/zcount_nib_enc.sv
// Four-bit leading-zero encoder: flags an empty nibble and gives the
// position of its first set bit counted from bit 3.
module zcount_nib_enc
    import zcount_pkg::*;
(
    input  logic [NIB_W-1:0] nib_i,
    output logic             empty_o,
    output logic [1:0]       lead_o
);
    always_comb begin
        empty_o = 1'b0;
        lead_o  = 2'd0;
        unique casez (nib_i)
            4'b1???: lead_o = 2'd0;
            4'b01??: lead_o = 2'd1;
            4'b001?: lead_o = 2'd2;
            4'b0001: lead_o = 2'd3;
            4'b0000: empty_o = 1'b1;
            default: empty_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/zcount_prep.sv
// Reverses the operand for low-end counting and left-aligns the low word
// for the narrow span, so one leading-zero search serves every mode.
module zcount_prep
    import zcount_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned HALF_W = 32
) (
    input  logic [DATA_W-1:0] operand_i,
    input  logic              trail_i,
    input  logic              narrow_i,
    output logic [DATA_W-1:0] field_o
);
    localparam int unsigned PAD_W = DATA_W - HALF_W;

    logic [DATA_W-1:0] rev;
    logic [DATA_W-1:0] picked;
    logic [HALF_W-1:0] low_sel;

    for (genvar b = 0; b < DATA_W; b++) begin : g_rev
        assign rev[b] = operand_i[DATA_W-1-b];
    end

    always_comb begin
        if (dir_e'(trail_i) == DIR_TRAIL) begin
            picked  = rev;
            low_sel = rev[DATA_W-1 -: HALF_W];
        end else begin
            picked  = operand_i;
            low_sel = operand_i[HALF_W-1:0];
        end
        if (span_e'(narrow_i) == SPAN_LOW) begin
            field_o = {low_sel, {PAD_W{1'b0}}};
        end else begin
            field_o = picked;
        end
    end
endmodule

// File: rtl/zcount_lz_tree.sv
// Leading-zero search: one encoder per nibble, then a parallel priority
// pick of the most significant non-empty nibble.
module zcount_lz_tree
    import zcount_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    localparam int unsigned CNT_W = $clog2(DATA_W) + 1
) (
    input  logic [DATA_W-1:0] field_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              all_zero_o
);
    localparam int unsigned NIB_CNT = DATA_W / NIB_W;

    logic [NIB_CNT-1:0] empty;
    logic [1:0]         lead [NIB_CNT];

    for (genvar j = 0; j < NIB_CNT; j++) begin : g_nib
        zcount_nib_enc u_enc (
            .nib_i   (field_i[DATA_W-1-j*NIB_W -: NIB_W]),
            .empty_o (empty[j]),
            .lead_o  (lead[j])
        );
    end

    always_comb begin
        count_o    = CNT_W'(DATA_W);
        all_zero_o = &empty;
        for (int j = NIB_CNT - 1; j >= 0; j--) begin
            if (!empty[j]) begin
                count_o = CNT_W'(j * NIB_W) + CNT_W'(lead[j]);
            end
        end
    end
endmodule

// File: rtl/zcount_unit.sv
module zcount_unit
    import zcount_pkg::*;
#(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned HALF_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [DATA_W-1:0] operand_i,
    input  logic              trail_i,
    input  logic              narrow_i,
    output logic [DATA_W-1:0] result_o
);
    localparam int unsigned CNT_W = $clog2(DATA_W) + 1;

    logic [DATA_W-1:0] field;
    logic [CNT_W-1:0]  tree_cnt;
    logic              tree_empty;
    logic [CNT_W-1:0]  cnt_next;
    logic [CNT_W-1:0]  cnt_q;

    zcount_prep #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_prep (
        .operand_i (operand_i),
        .trail_i   (trail_i),
        .narrow_i  (narrow_i),
        .field_o   (field)
    );

    zcount_lz_tree #(.DATA_W(DATA_W)) u_tree (
        .field_i    (field),
        .count_o    (tree_cnt),
        .all_zero_o (tree_empty)
    );

    // An empty field saturates at the width of the examined span.
    always_comb begin
        if (!tree_empty) begin
            cnt_next = tree_cnt;
        end else if (span_e'(narrow_i) == SPAN_LOW) begin
            cnt_next = CNT_W'(HALF_W);
        end else begin
            cnt_next = CNT_W'(DATA_W);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_next;
        end
    end

    always_comb begin
        result_o = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
    end
endmodule

// File: rtl/zcount_unit_chk.sv
module zcount_unit_chk #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned HALF_W = 32
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic [DATA_W-1:0] operand_i,
    input logic              trail_i,
    input logic              narrow_i,
    input logic [DATA_W-1:0] result_o
);
    localparam int unsigned CNT_W = $clog2(DATA_W) + 1;

    p_upper_zero_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        result_o[DATA_W-1:CNT_W] == '0);

    p_reset_clears_r9: assert property (@(posedge clk_i)
        rst_i |=> result_o == '0);

    p_full_bound_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        result_o <= DATA_W);

    p_full_empty_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!narrow_i && operand_i == '0) |=> result_o == DATA_W);

    p_narrow_bound_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        narrow_i |=> result_o <= HALF_W);

    p_narrow_empty_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (narrow_i && operand_i[HALF_W-1:0] == '0) |=> result_o == HALF_W);

    p_lead_top_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (!narrow_i && !trail_i && operand_i[DATA_W-1]) |=> result_o == '0);

    p_trail_bottom_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (trail_i && operand_i[0]) |=> result_o == '0);
endmodule

bind zcount_unit zcount_unit_chk #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .operand_i (operand_i),
    .trail_i   (trail_i),
    .narrow_i  (narrow_i),
    .result_o  (result_o)
);

// File: tb/zcount_unit_bench.sv
module zcount_unit_bench;
    logic        clk_i = 1'b0;
    logic        rst_i = 1'b1;
    logic [63:0] operand_i = '0;
    logic        trail_i = 1'b0;
    logic        narrow_i = 1'b0;
    logic [63:0] result_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [63:0] exp_q [$];
    string       tag_q [$];

    always #2 clk_i = ~clk_i;

    zcount_unit u_zcount_unit (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .operand_i (operand_i),
        .trail_i   (trail_i),
        .narrow_i  (narrow_i),
        .result_o  (result_o)
    );

    function automatic logic [63:0] model(logic [63:0] v, logic tr, logic nw);
        int w;
        int n;
        w = nw ? 32 : 64;
        n = 0;
        for (int k = 0; k < w; k++) begin
            if (v[tr ? k : (w - 1 - k)]) return 64'(n);
            n++;
        end
        return 64'(n);
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(logic [63:0] v, logic tr, logic nw, string tag);
        @(negedge clk_i);
        operand_i = v;
        trail_i   = tr;
        narrow_i  = nw;
        exp_q.push_back(model(v, tr, nw));
        tag_q.push_back(tag);
    endtask

    // Monitor: result registered at the posedge after the drive
    always @(posedge clk_i) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [63:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, result_o, e);
            check("R8 upper bits", {result_o[63:7], 7'd0}, 64'd0);
        end
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] r;
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        check("R9 reset value", result_o, 64'd0);
        rst_i = 1'b0;

        drive(64'd0, 1'b0, 1'b0, "R3 zero lead full");
        drive(64'd0, 1'b1, 1'b0, "R3 zero trail full");
        drive(64'd0, 1'b0, 1'b1, "R5 zero lead low");
        drive(64'd0, 1'b1, 1'b1, "R5 zero trail low");
        drive(64'hFFFF_FFFF_0000_0000, 1'b0, 1'b1, "R5 upper set lead low");
        drive(64'h8000_0001_0000_0000, 1'b1, 1'b1, "R5 upper set trail low");

        for (int i = 0; i < 64; i++) begin
            r = {$urandom, $urandom} | 64'h8000_0000_0000_0000;
            drive(r >> i, 1'b0, 1'b0, "R1 lead full");
            r = {$urandom, $urandom} | 64'd1;
            drive(r << i, 1'b1, 1'b0, "R2 trail full");
        end

        for (int i = 0; i < 32; i++) begin
            r[31:0]  = ($urandom | 32'h8000_0000) >> i;
            r[63:32] = $urandom;
            drive(r, 1'b0, 1'b1, "R6 lead low");
            drive({32'hFFFF_FFFF, r[31:0]}, 1'b0, 1'b1, "R4 upper ones lead");
            r[31:0]  = ($urandom | 32'd1) << i;
            r[63:32] = $urandom;
            drive(r, 1'b1, 1'b1, "R7 trail low");
            drive({32'hFFFF_FFFF, r[31:0]}, 1'b1, 1'b1, "R4 upper ones trail");
        end

        // back-to-back patterns: one-cycle latency
        drive(64'h0000_0000_0000_0100, 1'b0, 1'b0, "R9 latency a");
        drive(64'h0000_0000_0001_0000, 1'b1, 1'b0, "R9 latency b");
        drive(64'h0000_0000_0000_0001, 1'b0, 1'b1, "R9 latency c");
        @(negedge clk_i);
        @(negedge clk_i);

        // mid-run reset with a non-zero count pending
        operand_i = 64'd0;
        trail_i   = 1'b0;
        narrow_i  = 1'b0;
        @(negedge clk_i);
        check("R3 hold before reset", result_o, 64'd64);
        rst_i = 1'b1;
        @(negedge clk_i);
        check("R9 reset clears", result_o, 64'd0);
        rst_i = 1'b0;
        @(negedge clk_i);
        check("R9 after reset", result_o, 64'd64);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule